// File: doc/BRIEF.md
# Seven-Port Frame Switch Forwarding Engine

This engine decides where each frame waiting at the head of a switch port's queue goes. Each of the seven ports shows a data-available flag and the destination address of its head frame. Each port also carries the base address and prefix length of the subtree reached through it, plus the switch's own address as seen on that port. The engine works in rounds. It freezes the set of ports that hold a frame, then visits every destination/source pair in turn, one pair per clock. For each frame it raises a one-cycle send strobe toward a port whose subtree holds the destination, toward the uplink port, or toward the local handler. When the scan is over, it pops every frozen queue once.

A send to a port waits for that port's ready flag, and the scan holds on that pair until the flag is high. A frame that finds no path is removed silently at the end of the round. Payload movement and the local handler's reply are left to the neighbouring logic. That logic uses `src_o` together with the strobes to move the frame.

Top module: `fsw_forwarder`

## Requirements
- R1: While reset is held and after it is released with no frame pending, `send_o`, `local_o` and `deq_o` are all zero.
- R2: A round starts at the first rising edge in the idle state at which any `avail_i` bit is 1, and it freezes `avail_i` as the snapshot. A port whose flag rises later in that round is neither sent nor dequeued in it.
- R3: A frame matches port k when the top `prefix_len_i[k]` bits of its destination equal those of `remote_addr_i[k]`. A matching frame is sent with `send_o` one-hot at bit k and `src_o` equal to the source port index.
- R4: Destinations are scanned in the outer loop and sources in the inner loop, both in ascending order. A frame that matches several ports goes only to the lowest-indexed one, and each frame gets at most one strobe per round.
- R5: A frame is never sent back to the port it came from, even when its destination lies in that port's own subtree.
- R6: Port `UPLINK_PORT` (default 6) receives a frame from another port when the frame's destination matches the remote address of no port other than the uplink, including the frame's own source port.
- R7: When a frame on port s carries exactly `switch_addr_i[s]` and has not already been sent to a lower-indexed port, `local_o` pulses for one cycle with `src_o` = s, and no send follows for that frame.
- R8: A frame with no matching port and no uplink path produces no strobe, yet it is still dequeued at the end of the round.
- R9: A send to port d is issued only while `ready_i[d]` is 1. Until then the scan holds on that pair, and the round grows by one cycle for each held edge.
- R10: At most one bit of `send_o` is set in any cycle, and `send_o` and `local_o` are never set together.
- R11: `deq_o` equals the snapshot for exactly one cycle. With no holds it appears 50 rising edges after the edge that captured the snapshot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| avail_i | input | NUM_PORTS | Port queue holds a frame |
| ready_i | input | NUM_PORTS | Port can accept a send |
| frame_dst_i | input | NUM_PORTS*ADDR_W | Head-frame destination per port, port k at bits [k*ADDR_W +: ADDR_W] |
| remote_addr_i | input | NUM_PORTS*ADDR_W | Subtree base address per port |
| prefix_len_i | input | NUM_PORTS*PLEN_W | Significant leading bits of each remote address |
| switch_addr_i | input | NUM_PORTS*ADDR_W | Switch's own address per port |
| send_o | output | NUM_PORTS | One-cycle send strobe, one-hot by destination port |
| local_o | output | 1 | One-cycle local delivery strobe |
| src_o | output | IDX_W | Source port of the current strobe |
| deq_o | output | NUM_PORTS | One-cycle pop strobe per port |

## Verification
The assertions assume that a port's head-frame destination and the address configuration stay stable from the snapshot edge until the matching `deq_o` pulse. They also assume that a port keeps its available flag high until it is popped. The bench models each port queue as a flag that it clears only on seeing `deq_o`. It changes destinations, prefixes and ready flags only between rounds or at the planned stall and late-arrival points, and it drives every input on the falling edge.

// File: rtl/fsw_pkg.sv
package fsw_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SCAN,
    ST_DEQ
  } fsw_state_e;
endpackage

// File: rtl/fsw_prefix_match.sv
module fsw_prefix_match #(
  parameter int ADDR_W = 8,
  parameter int PLEN_W = $clog2(ADDR_W + 1)
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [PLEN_W-1:0] plen_i,
  output logic              hit_o
);
  logic [ADDR_W-1:0] ones;
  logic [ADDR_W-1:0] mask;

  assign ones  = '1;
  assign mask  = ~(ones >> plen_i);
  assign hit_o = ((addr_i ^ base_i) & mask) == '0;
endmodule

// File: rtl/fsw_pair_decide.sv
module fsw_pair_decide #(
  parameter int NUM_PORTS   = 7,
  parameter int ADDR_W      = 8,
  parameter int UPLINK_PORT = 6,
  parameter int PLEN_W      = $clog2(ADDR_W + 1),
  parameter int IDX_W       = $clog2(NUM_PORTS)
) (
  input  logic [IDX_W-1:0]            dst_idx_i,
  input  logic [IDX_W-1:0]            src_idx_i,
  input  logic                        elig_i,
  input  logic [ADDR_W-1:0]           frame_dst_i,
  input  logic [ADDR_W-1:0]           self_addr_i,
  input  logic [NUM_PORTS*ADDR_W-1:0] remote_addr_i,
  input  logic [NUM_PORTS*PLEN_W-1:0] prefix_len_i,
  output logic                        fwd_o,
  output logic                        local_o
);
  localparam logic [NUM_PORTS-1:0] UP_BIT = NUM_PORTS'(1) << UPLINK_PORT;

  logic [NUM_PORTS-1:0] hit_vec;
  logic                 same_port;
  logic                 is_uplink;
  logic                 no_other_hit;

  for (genvar k = 0; k < NUM_PORTS; k++) begin : g_match
    fsw_prefix_match #(
      .ADDR_W(ADDR_W),
      .PLEN_W(PLEN_W)
    ) i_match (
      .addr_i(frame_dst_i),
      .base_i(remote_addr_i[k*ADDR_W +: ADDR_W]),
      .plen_i(prefix_len_i[k*PLEN_W +: PLEN_W]),
      .hit_o (hit_vec[k])
    );
  end

  assign same_port    = dst_idx_i == src_idx_i;
  assign is_uplink    = dst_idx_i == IDX_W'(UPLINK_PORT);
  assign no_other_hit = (hit_vec & ~UP_BIT) == '0;

  assign fwd_o   = elig_i && !same_port && (hit_vec[dst_idx_i] || (is_uplink && no_other_hit));
  assign local_o = elig_i && same_port && (frame_dst_i == self_addr_i);
endmodule

// File: rtl/fsw_forwarder.sv
module fsw_forwarder
  import fsw_pkg::*;
#(
  parameter int NUM_PORTS   = 7,
  parameter int ADDR_W      = 8,
  parameter int UPLINK_PORT = 6,
  parameter int PLEN_W      = $clog2(ADDR_W + 1),
  parameter int IDX_W       = $clog2(NUM_PORTS)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [NUM_PORTS-1:0]        avail_i,
  input  logic [NUM_PORTS-1:0]        ready_i,
  input  logic [NUM_PORTS*ADDR_W-1:0] frame_dst_i,
  input  logic [NUM_PORTS*ADDR_W-1:0] remote_addr_i,
  input  logic [NUM_PORTS*PLEN_W-1:0] prefix_len_i,
  input  logic [NUM_PORTS*ADDR_W-1:0] switch_addr_i,
  output logic [NUM_PORTS-1:0]        send_o,
  output logic                        local_o,
  output logic [IDX_W-1:0]            src_o,
  output logic [NUM_PORTS-1:0]        deq_o
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_PORTS - 1);

  fsw_state_e           state_q;
  logic [IDX_W-1:0]     d_q, s_q;
  logic [NUM_PORTS-1:0] snap_q, tx_q;
  logic [NUM_PORTS-1:0] send_q, deq_q;
  logic                 local_q;
  logic [IDX_W-1:0]     src_q;

  logic                 elig, fwd, loc, stall;
  logic [ADDR_W-1:0]    cur_dst, cur_self;

  assign elig     = snap_q[s_q] && !tx_q[s_q];
  assign cur_dst  = frame_dst_i[s_q*ADDR_W +: ADDR_W];
  assign cur_self = switch_addr_i[s_q*ADDR_W +: ADDR_W];

  fsw_pair_decide #(
    .NUM_PORTS  (NUM_PORTS),
    .ADDR_W     (ADDR_W),
    .UPLINK_PORT(UPLINK_PORT),
    .PLEN_W     (PLEN_W),
    .IDX_W      (IDX_W)
  ) i_decide (
    .dst_idx_i    (d_q),
    .src_idx_i    (s_q),
    .elig_i       (elig),
    .frame_dst_i  (cur_dst),
    .self_addr_i  (cur_self),
    .remote_addr_i(remote_addr_i),
    .prefix_len_i (prefix_len_i),
    .fwd_o        (fwd),
    .local_o      (loc)
  );

  assign stall = fwd && !ready_i[d_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      d_q     <= '0;
      s_q     <= '0;
      snap_q  <= '0;
      tx_q    <= '0;
      send_q  <= '0;
      deq_q   <= '0;
      local_q <= 1'b0;
      src_q   <= '0;
    end else begin
      send_q  <= '0;
      deq_q   <= '0;
      local_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (|avail_i) begin
            snap_q  <= avail_i;
            tx_q    <= '0;
            d_q     <= '0;
            s_q     <= '0;
            state_q <= ST_SCAN;
          end
        end
        ST_SCAN: begin
          if (!stall) begin
            if (fwd) begin
              send_q    <= NUM_PORTS'(1) << d_q;
              src_q     <= s_q;
              tx_q[s_q] <= 1'b1;
            end
            if (loc) begin
              local_q   <= 1'b1;
              src_q     <= s_q;
              tx_q[s_q] <= 1'b1;
            end
            if (s_q == LAST_IDX) begin
              s_q <= '0;
              if (d_q == LAST_IDX) state_q <= ST_DEQ;
              else                 d_q     <= d_q + 1'b1;
            end else begin
              s_q <= s_q + 1'b1;
            end
          end
        end
        ST_DEQ: begin
          deq_q   <= snap_q;
          snap_q  <= '0;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign send_o  = send_q;
  assign local_o = local_q;
  assign src_o   = src_q;
  assign deq_o   = deq_q;

  AST_ONE_SEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(send_o) <= 1 && !(local_o && send_o != '0)); // R10

  AST_NO_HAIRPIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    send_o != '0 |-> !send_o[src_o]); // R5

  AST_SRC_IN_SNAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (send_o != '0 || local_o) |-> snap_q[src_o]); // R2

  AST_DEQ_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    deq_o != '0 |=> deq_o == '0 && send_o == '0 && !local_o); // R11

  for (genvar k = 0; k < NUM_PORTS; k++) begin : g_ast_ready
    AST_SEND_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      send_o[k] |-> $past(ready_i[k])); // R9
  end
endmodule

// File: tb/test_fsw_forwarder.sv
`timescale 1ns/1ps
module test_fsw_forwarder;
  localparam int NP = 7;
  localparam int AW = 8;
  localparam int PW = 4;

  typedef struct packed {
    logic [6:0]  av;
    logic [55:0] dst;
    logic [27:0] ex;
  } vec_t;

  // Codes per source: 0..6 destination port, 7 local, 8 nothing
  localparam vec_t VECS [5] = '{
    '{7'b0000001, {8'h00,8'h00,8'h00,8'h00,8'h00,8'h00,8'h25},
      {4'd8,4'd8,4'd8,4'd8,4'd8,4'd8,4'd1}},
    '{7'b1111111, {8'h85,8'hE7,8'h65,8'hF3,8'hC5,8'h05,8'h45},
      {4'd4,4'd6,4'd3,4'd7,4'd6,4'd0,4'd2}},
    '{7'b1000100, {8'hC5,8'h00,8'h00,8'h00,8'h45,8'h00,8'h00},
      {4'd8,4'd8,4'd8,4'd8,4'd8,4'd8,4'd8}},
    '{7'b0100010, {8'h00,8'hF5,8'h00,8'h00,8'h00,8'hF6,8'h00},
      {4'd8,4'd7,4'd8,4'd8,4'd8,4'd6,4'd8}},
    '{7'b1010000, {8'hF6,8'h00,8'hF4,8'h00,8'h00,8'h00,8'h00},
      {4'd7,4'd8,4'd7,4'd8,4'd8,4'd8,4'd8}}
  };

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic [NP-1:0]     avail_q = '0;
  logic [NP-1:0]     ready_q = '1;
  logic [NP*AW-1:0]  dst_q = '0;
  logic [NP*AW-1:0]  remote_q = {8'hE0,8'hA0,8'h80,8'h60,8'h40,8'h20,8'h00};
  logic [NP*PW-1:0]  plen_q = {4'd4,4'd3,4'd3,4'd3,4'd3,4'd3,4'd3};
  logic [NP*AW-1:0]  sw_q = {8'hF6,8'hF5,8'hF4,8'hF3,8'hF2,8'hF1,8'hF0};
  logic [NP-1:0]     send_o, deq_o;
  logic              local_o;
  logic [2:0]        src_o;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk_i = ~clk_i;

  fsw_forwarder #(.NUM_PORTS(NP), .ADDR_W(AW), .UPLINK_PORT(6)) i_fsw_forwarder (
    .clk_i(clk_i), .rst_ni(rst_ni), .avail_i(avail_q), .ready_i(ready_q),
    .frame_dst_i(dst_q), .remote_addr_i(remote_q), .prefix_len_i(plen_q),
    .switch_addr_i(sw_q), .send_o(send_o), .local_o(local_o), .src_o(src_o),
    .deq_o(deq_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic run_round(input logic [6:0] av, input logic [55:0] dsts,
                           input int release_at, input int late_at,
                           input logic [6:0] late_mask,
                           output logic [27:0] codes, output int len,
                           output logic [6:0] deq, output int first_send,
                           output bit multi);
    codes = {7{4'd8}};
    len = -1; deq = '0; first_send = -1; multi = 0;
    avail_q = av;
    dst_q = dsts;
    for (int cnt = 0; cnt < 3000; cnt++) begin
      @(posedge clk_i);
      @(negedge clk_i);
      if ($countones(send_o) > 1 || (local_o && |send_o)) multi = 1;
      if (|send_o) begin
        int d = 0;
        for (int k = 0; k < NP; k++) if (send_o[k]) d = k;
        codes[src_o*4 +: 4] = (codes[src_o*4 +: 4] == 4'd8) ? 4'(d) : 4'd15;
        if (first_send < 0) first_send = cnt;
      end
      if (local_o)
        codes[src_o*4 +: 4] = (codes[src_o*4 +: 4] == 4'd8) ? 4'd7 : 4'd15;
      if (cnt == release_at) ready_q = '1;
      if (cnt == late_at) avail_q = avail_q | late_mask;
      if (|deq_o) begin
        deq = deq_o;
        len = cnt;
        avail_q = avail_q & ~deq_o;
        break;
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [27:0] codes;
    logic [6:0]  deq;
    int          len, fs;
    bit          multi;

    repeat (3) @(negedge clk_i);
    chk(send_o == 0 && !local_o && deq_o == 0, "R1", "outputs in reset",
        {send_o, local_o, deq_o}, 0);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);
    chk(send_o == 0 && !local_o && deq_o == 0, "R1", "outputs idle",
        {send_o, local_o, deq_o}, 0);

    // Table of routing rounds: R3 R5 R6 R7 R8
    for (int v = 0; v < 5; v++) begin
      run_round(VECS[v].av, VECS[v].dst, -1, -1, '0, codes, len, deq, fs, multi);
      for (int s = 0; s < NP; s++)
        chk(codes[s*4 +: 4] == VECS[v].ex[s*4 +: 4], "R3/R5/R6/R7/R8",
            $sformatf("vec %0d src %0d route", v, s),
            codes[s*4 +: 4], VECS[v].ex[s*4 +: 4]);
      chk(deq == VECS[v].av, "R11", $sformatf("vec %0d dequeue mask", v), deq, VECS[v].av);
      chk(len == 50, "R11", $sformatf("vec %0d round length", v), len, 50);
      chk(!multi, "R10", $sformatf("vec %0d single strobe", v), multi, 0);
    end

    // R4: overlapping prefixes, lowest destination index wins, no hairpin
    remote_q[3*AW +: AW] = 8'h00;
    plen_q[3*PW +: PW]   = 4'd2;
    run_round(7'b0100001, {8'h00,8'h15,8'h00,8'h00,8'h00,8'h00,8'h05},
              -1, -1, '0, codes, len, deq, fs, multi);
    chk(codes[5*4 +: 4] == 4'd0, "R4", "overlap to lowest port", codes[5*4 +: 4], 0);
    chk(codes[0*4 +: 4] == 4'd3, "R4", "own-subtree frame to next match", codes[0 +: 4], 3);
    remote_q[3*AW +: AW] = 8'h60;
    plen_q[3*PW +: PW]   = 4'd3;

    // R9: destination not ready holds the scan
    ready_q = 7'b1111101;
    run_round(7'b0000001, {8'h00,8'h00,8'h00,8'h00,8'h00,8'h00,8'h25},
              20, -1, '0, codes, len, deq, fs, multi);
    chk(fs == 21, "R9", "send after ready rises", fs, 21);
    chk(codes[3:0] == 4'd1, "R9", "stalled frame delivered", codes[3:0], 1);
    chk(len == 63, "R9", "round stretched by stall", len, 63);

    // R2: a flag rising mid-round is ignored until the next round
    run_round(7'b0000001, {8'h00,8'h00,8'h05,8'h00,8'h00,8'h00,8'h25},
              -1, 5, 7'b0010000, codes, len, deq, fs, multi);
    chk(codes[4*4 +: 4] == 4'd8, "R2", "late frame not sent", codes[4*4 +: 4], 8);
    chk(deq == 7'b0000001, "R2", "late frame not dequeued", deq, 7'b0000001);
    run_round(7'b0010000, {8'h00,8'h00,8'h05,8'h00,8'h00,8'h00,8'h25},
              -1, -1, '0, codes, len, deq, fs, multi);
    chk(codes[4*4 +: 4] == 4'd0, "R2", "late frame sent next round", codes[4*4 +: 4], 0);
    chk(deq == 7'b0010000, "R2", "late frame dequeued next round", deq, 7'b0010000);

    repeat (4) @(negedge clk_i);
    chk(send_o == 0 && !local_o && deq_o == 0, "R1", "quiet when idle",
        {send_o, local_o, deq_o}, 0);

    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule